// File: doc/BRIEF.md
# Quad Double-Buffered Serial Converter Register Receiver

This block is the digital receive side of a four-channel digital-to-analog converter. A host shifts a 24-bit word in over three wires (an active-low select, a serial clock and a data line). The word carries a channel number, a broadcast flag and a 16-bit code. The shift register advances on every rising edge of the OR of select and serial clock, so either pin can act as the shift clock. A side effect follows from this: raising select while the serial clock is low adds one unintended shift.

Each channel holds two registers. The first is an input register. It copies the shifted code for as long as the active-low load pin is held low, either for the addressed channel only or, when the broadcast flag is set, for all four channels. The second is the converter register, which drives the outputs. All four converter registers take their input registers together on a rising edge of the update pin. A rising edge on the clear pin sets every register to zero or to midscale, depending on the clear-select pin, and this takes priority over loading and updating.

All pins are asynchronous to the system clock. Each is passed through a two-flop synchronizer, and edges are detected in the system clock domain, so the block is fully synchronous. A pin change reaches the registers on the third system clock edge after it is sampled.

Top module: `quad_dac_rx`

## Requirements
- R1: The word is shifted most significant bit first. Bits 23:22 hold the channel (00 selects channel A, 01 B, 10 C, 11 D), bit 21 is the broadcast flag, bits 20:16 have no effect, and bits 15:0 are the code. Channel k appears on `dac_words[16k+15:16k]`.
- R2: The shift register takes one data bit on each rising edge of (`cs_n_in` OR `sclk_in`). Toggling `cs_n_in` with `sclk_in` held low therefore shifts a word just as toggling the clock does.
- R3: If `cs_n_in` rises while `sclk_in` is low at the end of a word, one extra bit (the current data level) is shifted in, and the load that follows uses the displaced word.
- R4: While `load_n_in` is low and the broadcast flag is clear, only the addressed channel's input register takes the code. The other three keep their values.
- R5: While `load_n_in` is low and the broadcast flag is set, all four input registers take the code.
- R6: The outputs change only on a rising edge of `ldac_in`. On that edge all four take their input registers in the same cycle.
- R7: Holding `ldac_in` high or lowering it does not change the outputs, even when the input registers are reloaded in the meantime.
- R8: A rising edge on `clr_in` with `clr_mid_in` low sets all input and converter registers to 16'h0000.
- R9: A rising edge on `clr_in` with `clr_mid_in` high sets all input and converter registers to 16'h8000.
- R10: A clear edge that coincides with an update edge and an active load leaves the outputs at the clear value.
- R11: After the synchronous system reset `rst_n` is released, all outputs read 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Synchronous active-low system reset |
| cs_n_in | input | 1 | Active-low serial select; ORed with the serial clock |
| sclk_in | input | 1 | Serial clock |
| sdi_in | input | 1 | Serial data |
| load_n_in | input | 1 | Active-low level load into the input registers |
| ldac_in | input | 1 | Rising edge copies all input registers to the outputs |
| clr_in | input | 1 | Rising edge clears every register |
| clr_mid_in | input | 1 | Clear value select: 0 gives zero, 1 gives midscale |
| dac_words | output | 64 | Four converter registers; channel A in bits 15:0 |

## Verification
Words are driven three ways: with the serial clock under a held-low select, with select alone toggling over a parked clock, and with select raised while the clock is low. These separate a correct OR-based shift clock from one that uses only one pin, and show the one-bit displacement that turns a channel-B word into a channel-C load with a doubled code. The spare bits are set to non-zero values, and addressed loads are compared with broadcast loads, so wrong field decoding or a stray write to a neighbouring channel is detected. Updates are checked before the update edge, while the update pin is held high, and after it. Clears use both clear values, once alone and once together with a load and an update edge, to confirm the priority.

// File: rtl/quad_dac_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the serial word layout for the quad converter receiver.
// Assumes four channels, a 2-bit channel field and a 16-bit code.
package quad_dac_pkg;
    localparam int QD_CODE_W  = 16;
    localparam int QD_CH_N    = 4;
    localparam int QD_ADDR_W  = $clog2(QD_CH_N);
    localparam int QD_SPARE_W = 5;
    localparam int QD_WORD_W  = QD_ADDR_W + 1 + QD_SPARE_W + QD_CODE_W;

    // Serial word as it sits in the shift register once complete.
    typedef struct packed {
        logic [QD_ADDR_W-1:0]  chan;
        logic                  bcast;
        logic [QD_SPARE_W-1:0] spare;
        logic [QD_CODE_W-1:0]  code;
    } qd_word_t;
endpackage

// File: rtl/qd_sync.sv
`timescale 1ns/1ps
// qd_sync: two-flop synchronizer for a vector of independent pins.
// Assumes that each bit is unrelated to the others (no bus coherency).
// RST_VAL sets the level each bit reports during system reset.
module qd_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qd_rise.sv
`timescale 1ns/1ps
// qd_rise: rising-edge detector on a synchronized level.
// The pulse is combinational and lasts one cycle. PREV_RST should equal the idle
// level of the input so that reset release produces no false edge.
module qd_rise #(
    parameter logic PREV_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    // Keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= PREV_RST;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/qd_shifter.sv
`timescale 1ns/1ps
// qd_shifter: serial-in shift register, newest bit at bit 0.
// Assumes shift is a one-cycle pulse per serial clock edge.
module qd_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift one bit in per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/qd_bank.sv
`timescale 1ns/1ps
// qd_bank: per-channel input and converter registers.
// Input registers follow the code while load_en is high (addressed or broadcast).
// Converter registers take all input registers on upd. clr beats both.
module qd_bank #(
    parameter int CH_N   = 4,
    parameter int CODE_W = 16,
    parameter int ADDR_W = $clog2(CH_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     clr_mid,
    input  logic                     load_en,
    input  logic                     bcast,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        code,
    input  logic                     upd,
    output logic [CH_N*CODE_W-1:0]   in_words,
    output logic [CH_N*CODE_W-1:0]   dac_words
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] clr_val;
    assign clr_val = clr_mid ? MID_CODE : '0;

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        logic [CODE_W-1:0] in_r;
        logic [CODE_W-1:0] out_r;
        logic              hit;

        assign hit = load_en && (bcast || addr == ADDR_W'(ch));

        // Input register: clear first, then level load.
        always_ff @(posedge clk) begin
            if (!rst_n)   in_r <= '0;
            else if (clr) in_r <= clr_val;
            else if (hit) in_r <= code;
        end

        // Converter register: clear first, then joint update.
        always_ff @(posedge clk) begin
            if (!rst_n)   out_r <= '0;
            else if (clr) out_r <= clr_val;
            else if (upd) out_r <= in_r;
        end

        assign in_words[ch*CODE_W +: CODE_W]  = in_r;
        assign dac_words[ch*CODE_W +: CODE_W] = out_r;
    end
endmodule

// File: rtl/quad_dac_rx.sv
`timescale 1ns/1ps
// quad_dac_rx: serial receiver with double-buffered registers for four converter channels.
// Assumes that all pins are asynchronous and change slower than three system clocks.
// Idle pin levels at reset release: select high, load high, update and clear low.
module quad_dac_rx
    import quad_dac_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n_in,
    input  logic                         sclk_in,
    input  logic                         sdi_in,
    input  logic                         load_n_in,
    input  logic                         ldac_in,
    input  logic                         clr_in,
    input  logic                         clr_mid_in,
    output logic [QD_CH_N*QD_CODE_W-1:0] dac_words
);
    localparam int NPIN = 7;

    logic [NPIN-1:0]             pins_s;
    logic                        cs_s, sclk_s, sdi_s, load_n_s, ldac_s, clr_s, mid_s;
    logic                        sh_rise, upd_rise, clr_rise;
    logic [QD_WORD_W-1:0]        shift_q;
    qd_word_t                    word;
    logic [QD_CH_N*QD_CODE_W-1:0] in_words;
    logic                        unused_spare;

    qd_sync #(.W(NPIN), .RST_VAL(7'b1101000)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_in, sclk_in, sdi_in, load_n_in, ldac_in, clr_in, clr_mid_in}),
        .q     (pins_s)
    );
    assign {cs_s, sclk_s, sdi_s, load_n_s, ldac_s, clr_s, mid_s} = pins_s;

    qd_rise #(.PREV_RST(1'b1)) i_sh_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cs_s | sclk_s), .rise(sh_rise)
    );
    qd_rise #(.PREV_RST(1'b0)) i_upd_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ldac_s), .rise(upd_rise)
    );
    qd_rise #(.PREV_RST(1'b0)) i_clr_edge (
        .clk(clk), .rst_n(rst_n), .lvl(clr_s), .rise(clr_rise)
    );

    qd_shifter #(.W(QD_WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .shift(sh_rise), .din(sdi_s), .q(shift_q)
    );

    assign word         = qd_word_t'(shift_q);
    assign unused_spare = ^word.spare;

    qd_bank #(.CH_N(QD_CH_N), .CODE_W(QD_CODE_W), .ADDR_W(QD_ADDR_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_rise),
        .clr_mid   (mid_s),
        .load_en   (~load_n_s),
        .bcast     (word.bcast),
        .addr      (word.chan),
        .code      (word.code),
        .upd       (upd_rise),
        .in_words  (in_words),
        .dac_words (dac_words)
    );
endmodule

// File: rtl/qd_checker.sv
`timescale 1ns/1ps
// qd_checker: temporal properties of the receiver, bound to quad_dac_rx.
module qd_checker #(
    parameter int W  = 24,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  sr,
    input logic          sdi_s,
    input logic          sh_rise,
    input logic          upd_rise,
    input logic          clr_rise,
    input logic          mid_s,
    input logic [DW-1:0] in_words,
    input logic [DW-1:0] dac_words
);
    localparam logic [DW-1:0] ALL_MID = {(DW/16){16'h8000}};

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rise |=> sr == {$past(sr[W-2:0]), $past(sdi_s)});

    a_r2_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_rise |=> $stable(sr));

    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_rise && !clr_rise) |=> $stable(dac_words));

    a_r6_out_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_rise && !clr_rise) |=> dac_words == $past(in_words));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !mid_s) |=> dac_words == '0);

    a_r9_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && mid_s) |=> dac_words == ALL_MID);

    a_r10_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> in_words == dac_words);
endmodule

bind quad_dac_rx qd_checker #(.W(quad_dac_pkg::QD_WORD_W),
                              .DW(quad_dac_pkg::QD_CH_N * quad_dac_pkg::QD_CODE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr        (shift_q),
    .sdi_s     (sdi_s),
    .sh_rise   (sh_rise),
    .upd_rise  (upd_rise),
    .clr_rise  (clr_rise),
    .mid_s     (mid_s),
    .in_words  (in_words),
    .dac_words (dac_words)
);

// File: tb/test_quad_dac_rx.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_quad_dac_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
    logic ldac = 1'b0, clr = 1'b0, clr_mid = 1'b0;
    logic [63:0] dac_words;

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_sr = '0;
    logic [15:0] m_in  [4];
    logic [15:0] m_out [4];

    always #2 clk = ~clk;

    quad_dac_rx i_quad_dac_rx (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .sdi_in(sdi),
        .load_n_in(load_n), .ldac_in(ldac), .clr_in(clr), .clr_mid_in(clr_mid),
        .dac_words(dac_words)
    );

    task automatic step();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_ch(input string tag, input int ch, input logic [15:0] exp);
        logic [15:0] act;
        act = dac_words[ch*16 +: 16];
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int ch = 0; ch < 4; ch++) check_ch(tag, ch, m_out[ch]);
    endtask

    // mode 0: serial clock under low select; 1: select only; 2: select rises with clock low
    task automatic send_word(input logic [23:0] w, input int mode);
        if (mode == 1) begin
            for (int i = 23; i >= 0; i--) begin
                sdi = w[i]; cs_n = 1'b0; step();
                cs_n = 1'b1; step();
                m_sr = {m_sr[22:0], w[i]};
            end
        end else begin
            cs_n = 1'b0; step();
            for (int i = 23; i >= 0; i--) begin
                sdi = w[i]; sclk = 1'b0; step();
                sclk = 1'b1; step();
                m_sr = {m_sr[22:0], w[i]};
            end
            if (mode == 2) begin
                sclk = 1'b0; step();
                cs_n = 1'b1; step();
                m_sr = {m_sr[22:0], sdi};
            end else begin
                cs_n = 1'b1; step();
                sclk = 1'b0; step();
            end
        end
    endtask

    task automatic model_load();
        for (int ch = 0; ch < 4; ch++)
            if (m_sr[21] || m_sr[23:22] == 2'(ch)) m_in[ch] = m_sr[15:0];
    endtask

    task automatic pulse_load();
        load_n = 1'b0; step();
        load_n = 1'b1; step();
        model_load();
    endtask

    task automatic pulse_ldac();
        ldac = 1'b1; step();
        ldac = 1'b0; step();
        for (int ch = 0; ch < 4; ch++) m_out[ch] = m_in[ch];
    endtask

    task automatic model_clear(input logic mid);
        for (int ch = 0; ch < 4; ch++) begin
            m_in[ch]  = mid ? 16'h8000 : 16'h0000;
            m_out[ch] = m_in[ch];
        end
    endtask

    task automatic t_reset();
        for (int ch = 0; ch < 4; ch++) begin m_in[ch] = '0; m_out[ch] = '0; end
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step();
        check_all("R11 reset");
    endtask

    task automatic t_addressed();
        send_word({2'b00, 1'b0, 5'b10101, 16'h1A2B}, 0); pulse_load();
        send_word({2'b01, 1'b0, 5'b01010, 16'h3C4D}, 0); pulse_load();
        send_word({2'b10, 1'b0, 5'b11111, 16'h5E6F}, 0); pulse_load();
        send_word({2'b11, 1'b0, 5'b10001, 16'h7081}, 0); pulse_load();
        check_all("R6 before update");
        pulse_ldac();
        check_all("R1 addressed fields");
        send_word({2'b10, 1'b0, 5'b00110, 16'hC0DE}, 0); pulse_load(); pulse_ldac();
        check_all("R4 single channel");
    endtask

    task automatic t_broadcast();
        send_word({2'b01, 1'b1, 5'b00000, 16'hBEEF}, 0); pulse_load(); pulse_ldac();
        check_all("R5 broadcast");
    endtask

    task automatic t_cs_only();
        send_word({2'b11, 1'b0, 5'b11000, 16'h0F0F}, 1); pulse_load(); pulse_ldac();
        check_all("R2 select as clock");
    endtask

    task automatic t_update_level();
        ldac = 1'b1; step();
        for (int ch = 0; ch < 4; ch++) m_out[ch] = m_in[ch];
        send_word({2'b00, 1'b0, 5'b00000, 16'h4242}, 0); pulse_load();
        check_all("R7 update held high");
        ldac = 1'b0; step();
        check_all("R7 update falling");
        pulse_ldac();
        check_all("R6 next rising edge");
    endtask

    task automatic t_extra_bit();
        send_word({2'b01, 1'b0, 5'b00000, 16'hA5C3}, 2); pulse_load(); pulse_ldac();
        check_ch("R3 displaced word to C", 2, 16'h4B87);
        check_all("R3 displaced word");
    endtask

    task automatic t_clear(input logic mid, input string tag);
        clr_mid = mid; step();
        clr = 1'b1; step();
        clr = 1'b0; step();
        model_clear(mid);
        check_all(tag);
        pulse_ldac();
        check_all(tag);
    endtask

    task automatic t_priority();
        send_word({2'b00, 1'b0, 5'b00000, 16'h1111}, 0); pulse_load(); pulse_ldac();
        clr_mid = 1'b1; step();
        send_word({2'b01, 1'b0, 5'b00000, 16'h2222}, 0);
        load_n = 1'b0; ldac = 1'b1; clr = 1'b1; step();
        model_clear(1'b1);
        check_all("R10 clear wins");
        model_load();
        load_n = 1'b1; ldac = 1'b0; clr = 1'b0; step();
        check_all("R10 after release");
        pulse_ldac();
        check_all("R10 load resumes");
    endtask

    initial begin
        t_reset();
        t_addressed();
        t_broadcast();
        t_cs_only();
        t_update_level();
        t_extra_bit();
        t_clear(1'b0, "R8 clear zero");
        t_broadcast();
        t_clear(1'b1, "R9 clear midscale");
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule